// File: doc/BRIEF.md
# Multifunction Arithmetic and Logic Unit

A purely combinational arithmetic and logic unit with a parameterised operand width (8 and 16 bits are the intended sizes). Two operands and a carry/borrow input are combined under a 5-bit function select. The 32 codes cover constants, operand pass and inversion, ten bitwise logic terms, negation, increment and decrement, plain and carry-chained add and subtract, reverse subtraction and signed saturating add and subtract.

Besides the result, the unit produces a carry/borrow flag, a zero flag and a signed-overflow flag. It holds no state. A surrounding datapath registers its operands and the results as it needs.

All arithmetic codes share one adder. A front end picks the two adder inputs and the carry-in for each code. The flags come from that single sum.

Top module: `multifunc_alu`

## Requirements
- R1: Constant codes: 00000 gives all zeros, 00001 gives 1, 00010 gives all ones, and 00011 gives the most negative value (MSB set, all other bits clear).
- R2: 00100 passes operand A and 00101 passes operand B. 00110 gives the bitwise inverse of A and 00111 the bitwise inverse of B.
- R3: Logic codes: 01000 A&B, 01001 A&~B, 01010 ~A&B, 01011 ~(A|B), 01100 A|B, 01101 A|~B, 01110 ~A|B, 01111 ~(A&B), 10000 A^B, 10001 ~(A^B).
- R4: 10010 gives 0-A and 10011 gives 0-B. The carry flag is 1 when the operand is nonzero (a borrow occurred). The overflow flag is 1 only when the operand is the most negative value.
- R5: 10100 gives A+1 and 10101 gives B+1; the carry flag is the carry out of the MSB. 10110 gives A-1 and 10111 gives B-1; the carry flag is 1 when the operand is zero (borrow). In both cases the overflow flag marks signed overflow.
- R6: 11000 gives A+B and 11001 gives A+B+Ci. The carry flag is the unsigned carry out of the MSB. The overflow flag is 1 when the signed sum is out of range.
- R7: 11011 gives A-B, 11100 gives A-B-Ci, 11110 gives B-A and 11111 gives B-A-Ci. Ci is a borrow. The carry flag is 1 when the unsigned minuend is smaller than the subtrahend plus the borrow. The overflow flag marks signed overflow.
- R8: 11010 (A+B) and 11101 (A-B) saturate as signed values. A positive overflow gives the largest positive value and a negative overflow gives the most negative value, and the overflow flag is 1 when clamping happened. The carry flag is the raw carry (11010) or borrow (11101).
- R9: The zero flag is 1 exactly when the result is all zeros, for every code.
- R10: For every code below 10010 the carry and overflow flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| carry_in | input | 1 | Carry or borrow input |
| func_sel | input | 5 | Function select code |
| result | output | WIDTH | Result |
| carry_out | output | 1 | Carry out of the MSB, or borrow for subtract-type codes |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow, or saturation clamp |

## Verification
Some properties hold for every input, and the bound checker tests them whenever the inputs change. These are the zero flag matching the result, quiet flags on non-arithmetic codes, the saturating result being one of the two limits when it clamps, the A pass-through, and the plain add's carry/sum pair. The exact value of each remaining code can only be shown by the bench's scoreboard. The same goes for the borrow sense of the subtract family, the overflow corners at the signed limits and the effect of the carry/borrow input. The scoreboard checks these against a separate signed-integer model, using corner operands and random vectors.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ZERO   = 5'b00000,
        OP_ONE    = 5'b00001,
        OP_ONES   = 5'b00010,
        OP_MINV   = 5'b00011,
        OP_PASSA  = 5'b00100,
        OP_PASSB  = 5'b00101,
        OP_INVA   = 5'b00110,
        OP_INVB   = 5'b00111,
        OP_AND    = 5'b01000,
        OP_ANDNB  = 5'b01001,
        OP_NAANDB = 5'b01010,
        OP_NOR    = 5'b01011,
        OP_OR     = 5'b01100,
        OP_ORNB   = 5'b01101,
        OP_NAORB  = 5'b01110,
        OP_NAND   = 5'b01111,
        OP_XOR    = 5'b10000,
        OP_XNOR   = 5'b10001,
        OP_NEGA   = 5'b10010,
        OP_NEGB   = 5'b10011,
        OP_INCA   = 5'b10100,
        OP_INCB   = 5'b10101,
        OP_DECA   = 5'b10110,
        OP_DECB   = 5'b10111,
        OP_ADD    = 5'b11000,
        OP_ADDC   = 5'b11001,
        OP_ADDS   = 5'b11010,
        OP_SUB    = 5'b11011,
        OP_SUBB   = 5'b11100,
        OP_SUBS   = 5'b11101,
        OP_RSUB   = 5'b11110,
        OP_RSUBB  = 5'b11111
    } alu_op_e;

    // First code that uses the shared adder
    localparam logic [4:0] ARITH_BASE = 5'b10010;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] f
);
    localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ONE_VAL = {{(WIDTH-1){1'b0}}, 1'b1};

    always_comb begin
        case (op)
            OP_ZERO:   f = '0;
            OP_ONE:    f = ONE_VAL;
            OP_ONES:   f = '1;
            OP_MINV:   f = MIN_NEG;
            OP_PASSA:  f = a;
            OP_PASSB:  f = b;
            OP_INVA:   f = ~a;
            OP_INVB:   f = ~b;
            OP_AND:    f = a & b;
            OP_ANDNB:  f = a & ~b;
            OP_NAANDB: f = ~a & b;
            OP_NOR:    f = ~(a | b);
            OP_OR:     f = a | b;
            OP_ORNB:   f = a | ~b;
            OP_NAORB:  f = ~a | b;
            OP_NAND:   f = ~(a & b);
            OP_XOR:    f = a ^ b;
            OP_XNOR:   f = ~(a ^ b);
            default:   f = '0;
        endcase
    end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             ci,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] f,
    output logic             co,
    output logic             ov
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] ONE_VAL = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] x_in;
    logic [WIDTH-1:0] y_in;
    logic             c_in;
    logic             borrow_kind;
    logic             sat_en;
    logic [WIDTH:0]   sum;

    // Adder front end: subtraction is x + ~y + 1, a borrow input becomes ~ci
    always_comb begin
        x_in        = '0;
        y_in        = '0;
        c_in        = 1'b0;
        borrow_kind = 1'b0;
        sat_en      = 1'b0;
        case (op)
            OP_NEGA:  begin y_in = ~a; c_in = 1'b1; borrow_kind = 1'b1; end
            OP_NEGB:  begin y_in = ~b; c_in = 1'b1; borrow_kind = 1'b1; end
            OP_INCA:  begin x_in = a; c_in = 1'b1; end
            OP_INCB:  begin x_in = b; c_in = 1'b1; end
            OP_DECA:  begin x_in = a; y_in = ~ONE_VAL; c_in = 1'b1; borrow_kind = 1'b1; end
            OP_DECB:  begin x_in = b; y_in = ~ONE_VAL; c_in = 1'b1; borrow_kind = 1'b1; end
            OP_ADD:   begin x_in = a; y_in = b; end
            OP_ADDC:  begin x_in = a; y_in = b; c_in = ci; end
            OP_ADDS:  begin x_in = a; y_in = b; sat_en = 1'b1; end
            OP_SUB:   begin x_in = a; y_in = ~b; c_in = 1'b1; borrow_kind = 1'b1; end
            OP_SUBB:  begin x_in = a; y_in = ~b; c_in = ~ci; borrow_kind = 1'b1; end
            OP_SUBS:  begin x_in = a; y_in = ~b; c_in = 1'b1; borrow_kind = 1'b1; sat_en = 1'b1; end
            OP_RSUB:  begin x_in = b; y_in = ~a; c_in = 1'b1; borrow_kind = 1'b1; end
            OP_RSUBB: begin x_in = b; y_in = ~a; c_in = ~ci; borrow_kind = 1'b1; end
            default:  ;
        endcase
    end

    assign sum = {1'b0, x_in} + {1'b0, y_in} + {{WIDTH{1'b0}}, c_in};
    assign ov  = (x_in[MSB] == y_in[MSB]) && (sum[MSB] != x_in[MSB]);
    assign co  = borrow_kind ? ~sum[WIDTH] : sum[WIDTH];

    always_comb begin
        if (sat_en && ov) begin
            f = x_in[MSB] ? MIN_NEG : MAX_POS;
        end else begin
            f = sum[MSB:0];
        end
    end
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] logic_f,
    input  logic [WIDTH-1:0] arith_f,
    input  logic             arith_co,
    input  logic             arith_ov,
    output logic [WIDTH-1:0] f,
    output logic             co,
    output logic             z,
    output logic             v
);
    logic use_arith;

    assign use_arith = (op >= ARITH_BASE);
    assign f         = use_arith ? arith_f : logic_f;
    assign co        = use_arith & arith_co;
    assign v         = use_arith & arith_ov;
    assign z         = ~|f;
endmodule

// File: rtl/multifunc_alu.sv
module multifunc_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic [4:0]       func_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             zero,
    output logic             overflow
);
    alu_op_e          opc;
    logic [WIDTH-1:0] lg_f;
    logic [WIDTH-1:0] ar_f;
    logic             ar_co;
    logic             ar_ov;

    assign opc = alu_op_e'(func_sel);

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a  (op_a),
        .b  (op_b),
        .op (opc),
        .f  (lg_f)
    );

    alu_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .a  (op_a),
        .b  (op_b),
        .ci (carry_in),
        .op (opc),
        .f  (ar_f),
        .co (ar_co),
        .ov (ar_ov)
    );

    alu_result_mux #(.WIDTH(WIDTH)) u_mux (
        .op       (opc),
        .logic_f  (lg_f),
        .arith_f  (ar_f),
        .arith_co (ar_co),
        .arith_ov (ar_ov),
        .f        (result),
        .co       (carry_out),
        .z        (zero),
        .v        (overflow)
    );
endmodule

// File: rtl/multifunc_alu_chk.sv
module multifunc_alu_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [4:0]       func_sel,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             zero,
    input logic             overflow
);
    localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};

    always_comb begin
        p_zero_flag_r9: assert (zero == (result == '0));
        if (func_sel < 5'b10010) begin
            p_flags_quiet_r10: assert (!carry_out && !overflow);
        end
        if ((func_sel == 5'b11010 || func_sel == 5'b11101) && overflow) begin
            p_sat_clamp_r8: assert (result == MIN_NEG || result == MAX_POS);
        end
        if (func_sel == 5'b00100) begin
            p_pass_a_r2: assert (result == op_a);
        end
        if (func_sel == 5'b11000) begin
            p_add_carry_r6: assert ({carry_out, result} == ({1'b0, op_a} + {1'b0, op_b}));
        end
    end
endmodule

bind multifunc_alu multifunc_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .func_sel  (func_sel),
    .result    (result),
    .carry_out (carry_out),
    .zero      (zero),
    .overflow  (overflow)
);

// File: tb/tb_multifunc_alu.sv
module tb_multifunc_alu;
    localparam int W = 16;
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam longint SMAX = (longint'(1) <<< (W-1)) - 1;
    localparam longint SMIN = -(longint'(1) <<< (W-1));

    typedef struct {
        logic [4:0]   s;
        logic [W-1:0] f;
        logic         co;
        logic         z;
        logic         v;
    } exp_t;

    logic         clk = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         ci_i = 1'b0;
    logic [4:0]   s_i = '0;
    logic [W-1:0] f_o;
    logic         co_o, z_o, v_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    exp_t sb_q[$];

    always #4 clk = ~clk; // 125 MHz

    multifunc_alu #(.WIDTH(W)) dut (
        .op_a(a_i), .op_b(b_i), .carry_in(ci_i), .func_sel(s_i),
        .result(f_o), .carry_out(co_o), .zero(z_o), .overflow(v_o)
    );

    function automatic string req_tag(logic [4:0] s);
        if (s <= 5'd3) return "R1";
        if (s <= 5'd7) return "R2";
        if (s <= 5'd17) return "R3";
        if (s <= 5'd19) return "R4";
        if (s <= 5'd23) return "R5";
        if (s == 5'd26 || s == 5'd29) return "R8";
        if (s <= 5'd25) return "R6";
        return "R7";
    endfunction

    function automatic longint sval(logic [W-1:0] x);
        return x[W-1] ? longint'(x) - (longint'(1) <<< W) : longint'(x);
    endfunction

    function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic ci, logic [4:0] s);
        exp_t e;
        longint sa = sval(a);
        longint sb = sval(b);
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint c = longint'(ci);
        longint ex = 0;
        bit arith = 1;
        bit sat = 0;
        e.s = s; e.co = 0; e.v = 0; e.f = '0;
        case (s)
            5'd0:  begin arith = 0; e.f = '0; end
            5'd1:  begin arith = 0; e.f = 1; end
            5'd2:  begin arith = 0; e.f = '1; end
            5'd3:  begin arith = 0; e.f = MINV; end
            5'd4:  begin arith = 0; e.f = a; end
            5'd5:  begin arith = 0; e.f = b; end
            5'd6:  begin arith = 0; e.f = ~a; end
            5'd7:  begin arith = 0; e.f = ~b; end
            5'd8:  begin arith = 0; e.f = a & b; end
            5'd9:  begin arith = 0; e.f = a & ~b; end
            5'd10: begin arith = 0; e.f = ~a & b; end
            5'd11: begin arith = 0; e.f = ~(a | b); end
            5'd12: begin arith = 0; e.f = a | b; end
            5'd13: begin arith = 0; e.f = a | ~b; end
            5'd14: begin arith = 0; e.f = ~a | b; end
            5'd15: begin arith = 0; e.f = ~(a & b); end
            5'd16: begin arith = 0; e.f = a ^ b; end
            5'd17: begin arith = 0; e.f = ~(a ^ b); end
            5'd18: begin ex = -sa; e.co = (a != 0); end
            5'd19: begin ex = -sb; e.co = (b != 0); end
            5'd20: begin ex = sa + 1; e.co = (a == '1); end
            5'd21: begin ex = sb + 1; e.co = (b == '1); end
            5'd22: begin ex = sa - 1; e.co = (a == 0); end
            5'd23: begin ex = sb - 1; e.co = (b == 0); end
            5'd24: begin ex = sa + sb; e.co = ((ua + ub) >>> W) != 0; end
            5'd25: begin ex = sa + sb + c; e.co = ((ua + ub + c) >>> W) != 0; end
            5'd26: begin ex = sa + sb; sat = 1; e.co = ((ua + ub) >>> W) != 0; end
            5'd27: begin ex = sa - sb; e.co = (ua < ub); end
            5'd28: begin ex = sa - sb - c; e.co = (ua < ub + c); end
            5'd29: begin ex = sa - sb; sat = 1; e.co = (ua < ub); end
            5'd30: begin ex = sb - sa; e.co = (ub < ua); end
            default: begin ex = sb - sa - c; e.co = (ub < ua + c); end
        endcase
        if (arith) begin
            e.v = (ex > SMAX) || (ex < SMIN);
            if (sat && ex > SMAX) e.f = MAXV;
            else if (sat && ex < SMIN) e.f = MINV;
            else e.f = ex[W-1:0];
        end
        e.z = (e.f == '0);
        return e;
    endfunction

    // Driver: apply one vector per cycle and queue its expected outcome
    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic ci, logic [4:0] s);
        @(posedge clk);
        a_i = a; b_i = b; ci_i = ci; s_i = s;
        sb_q.push_back(model(a, b, ci, s));
    endtask

    task automatic check1(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (sel=%b a=%h b=%h ci=%b)",
                     req, what, act, expv, s_i, a_i, b_i, ci_i);
        end
    endtask

    // Monitor: compare at the falling edge, half a cycle after the drive
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            string tg;
            e = sb_q.pop_front();
            tg = req_tag(e.s);
            check1(f_o == e.f, tg, "result", longint'(f_o), longint'(e.f));
            check1(co_o == e.co, (e.s < 5'd18) ? "R10" : tg, "carry", longint'(co_o), longint'(e.co));
            check1(v_o == e.v, (e.s < 5'd18) ? "R10" : tg, "overflow", longint'(v_o), longint'(e.v));
            check1(z_o == e.z, "R9", "zero", longint'(z_o), longint'(e.z));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        logic [W-1:0] pa [10];
        logic [W-1:0] pb [10];
        pa = '{16'h0000, MAXV, MINV, MINV, 16'hFFFF, 16'h0001, 16'h1234, MAXV, 16'h8001, 16'h00FF};
        pb = '{16'h0000, 16'h0001, 16'h0001, MINV, 16'h0001, 16'hFFFF, 16'h00FF, MAXV, 16'h0002, 16'h00FF};
        // Idle inputs: code 00000 with zero operands, R1 and R9
        drive('0, '0, 1'b0, 5'b00000);
        // Full sweep of codes over corner operand pairs, both Ci values (R1..R10)
        for (int s = 0; s < 32; s++) begin
            for (int k = 0; k < 10; k++) begin
                drive(pa[k], pb[k], 1'b0, 5'(s));
                drive(pa[k], pb[k], 1'b1, 5'(s));
            end
        end
        // R4 negate most negative, R5 increment most positive, R8 clamp both ways
        drive(MINV, 16'h0, 1'b0, 5'b10010);
        drive(MAXV, 16'h0, 1'b0, 5'b10100);
        drive(16'h7000, 16'h7000, 1'b0, 5'b11010);
        drive(16'h9000, 16'h7000, 1'b0, 5'b11101);
        // R7 borrow chain: Ci as borrow at equal operands
        drive(16'h0005, 16'h0005, 1'b1, 5'b11100);
        drive(16'h0005, 16'h0005, 1'b1, 5'b11111);
        // Random vectors over all codes
        for (int n = 0; n < 600; n++) begin
            drive(W'($urandom), W'($urandom), 1'($urandom), 5'($urandom));
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        finish_run();
    end

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule